// File: doc/BRIEF.md
# Serial Word Shifter with Selectable MSB Alignment

This block is the data path of a synchronous serial port: a transmit shifter and a receive assembler that run on a common bit-clock enable. Words move most significant bit first. The parallel side is a 24-bit fractional register. A word-length select sets how many bit periods one word takes. The lengths are 8, 12, 16, 24 and 32 bits.

Shorter words are left-justified against an anchor bit, and this happens in both directions. With the alignment input low, the anchor is bit 23. With it high, the anchor is bit 15, so that 16-bit fractional data needs no software shifting. With the anchor at bit 15, only the 8, 12 and 16-bit lengths are meaningful. Combining it with 24 or 32 bits gives undefined data.

The block counts bits within the current word. It loads the transmit word at the first bit of each word. When the last bit of a word has been sampled, it presents the assembled receive word together with a one-cycle completion strobe.

Top module: `serial_word_shifter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tx_sdo`, `rx_word` and `word_done` are all zero.
- R2: `wl_sel` encodes the word length as 0=8, 1=12, 2=16, 3=24, 4=32 bits, and codes 5 to 7 act as 24 bits. A word spans exactly that many enabled bit periods.
- R3: With `align16` low, `tx_sdo` carries `tx_word[23]`, then `[22]` and so on downward. In 32-bit words, the 8 periods after bit 0 send zero.
- R4: With `align16` high, transmission starts at `tx_word[15]` and moves downward for the word length. Bits 23..16 of `tx_word` are never sent.
- R5: With `align16` low, the first received bit lands at `rx_word[23]` and later bits fill downward. Bits below the word are zero. In 32-bit words, only the first 24 bits are kept.
- R6: With `align16` high, the first received bit lands at `rx_word[15]` and later bits fill downward. Bits 23..16 and the bits below the word are zero.
- R7: `word_done` is high for exactly the one cycle after the enabled edge that samples the last bit of a word. `rx_word` changes only in that cycle.
- R8: When `bit_en` is low, nothing advances: `tx_sdo`, `rx_word` and the bit position all hold.
- R9: `tx_word` is captured at the enabled edge of a word's first bit. Later changes within the word have no effect on the bits sent.
- R10: `rx_sdi` is sampled at each enabled rising edge, and `tx_sdo` shows the new bit one cycle after it. With `bit_en` held high, words follow back to back with no idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit clock enable, one bit period per high cycle |
| wl_sel | input | 3 | Word length code (R2) |
| align16 | input | 1 | Anchor select: 0 = bit 23, 1 = bit 15 |
| tx_word | input | DATA_W (24) | Parallel word to transmit |
| rx_sdi | input | 1 | Serial receive data |
| tx_sdo | output | 1 | Serial transmit data, registered |
| rx_word | output | DATA_W (24) | Last assembled receive word, registered |
| word_done | output | 1 | One-cycle strobe when a word completes |

## Verification
Every result of the block is one register stage behind the enabled edge that causes it. `tx_sdo` shows bit i in the cycle after the edge that shifts bit i. `word_done` and the new `rx_word` appear in the cycle after the edge that samples the last bit. The bench drives `bit_en`, `rx_sdi` and the parallel inputs at the falling edge and lets one rising edge pass. It then checks all three outputs at the next falling edge, so each check lands exactly in the cycle its result is due. Idle periods between bit enables are checked for held outputs and a low strobe. A word that uses the 24-bit length with `align16` high is reported as an illegal configuration, and its data is not checked.

// File: rtl/sws_pkg.sv
`timescale 1ns/1ps
package sws_pkg;
  typedef enum logic [2:0] {
    WL_8  = 3'd0,
    WL_12 = 3'd1,
    WL_16 = 3'd2,
    WL_24 = 3'd3,
    WL_32 = 3'd4
  } wl_code_e;
endpackage

// File: rtl/sws_bit_counter.sv
`timescale 1ns/1ps
module sws_bit_counter #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic [LEN_W-1:0] len_bits,
  output logic             first_bit,
  output logic             last_bit
);
  logic [LEN_W-1:0] pos;

  assign first_bit = (pos == '0);
  assign last_bit  = (pos >= len_bits - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst)         pos <= '0;
    else if (bit_en) pos <= last_bit ? '0 : pos + LEN_W'(1);
  end

  // R8
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(pos));
endmodule

// File: rtl/sws_tx_shifter.sv
`timescale 1ns/1ps
module sws_tx_shifter #(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              first_bit,
  input  logic [IDX_W-1:0]  anchor,
  input  logic [DATA_W-1:0] tx_word,
  output logic              tx_sdo
);
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      tx_sdo <= 1'b0;
    end else if (bit_en) begin
      if (first_bit) begin
        tx_sdo <= tx_word[anchor];
        shreg  <= tx_word << 1;
      end else begin
        tx_sdo <= shreg[anchor];
        shreg  <= shreg << 1;
      end
    end
  end

  // R8
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_sdo));
endmodule

// File: rtl/sws_rx_assembler.sv
`timescale 1ns/1ps
module sws_rx_assembler #(
  parameter int DATA_W     = 24,
  parameter int NARROW_MSB = 15,
  parameter int MAX_LEN    = 32,
  parameter int LEN_W      = 6,
  parameter int IDX_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              last_bit,
  input  logic              align16,
  input  logic [IDX_W-1:0]  anchor,
  input  logic [LEN_W-1:0]  len_bits,
  input  logic              rx_sdi,
  output logic [DATA_W-1:0] rx_word,
  output logic              word_done
);
  logic [MAX_LEN-2:0] hist;
  logic [MAX_LEN-1:0] hist_nxt, field, wide, keep;
  logic [LEN_W-1:0]   span;
  logic [DATA_W-1:0]  aligned;

  assign hist_nxt = {hist, rx_sdi};
  assign span     = LEN_W'(anchor) + LEN_W'(1);

  always_comb begin
    field = hist_nxt & ~({MAX_LEN{1'b1}} << len_bits);
    if (len_bits > span) wide = field >> (len_bits - span);
    else                 wide = field << (span - len_bits);
    keep    = ~({MAX_LEN{1'b1}} << span);
    aligned = DATA_W'(wide & keep);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= '0;
      rx_word   <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= bit_en && last_bit;
      if (bit_en) begin
        hist <= hist_nxt[MAX_LEN-2:0];
        if (last_bit) rx_word <= aligned;
      end
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);
  // R7
  rx_word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_done |-> $stable(rx_word));
  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (word_done && $past(align16)) |-> (rx_word[DATA_W-1:NARROW_MSB+1] == '0));
endmodule

// File: rtl/serial_word_shifter.sv
`timescale 1ns/1ps
module serial_word_shifter #(
  parameter int DATA_W     = 24,
  parameter int NARROW_MSB = 15,
  parameter int MAX_LEN    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [2:0]        wl_sel,
  input  logic              align16,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              rx_sdi,
  output logic              tx_sdo,
  output logic [DATA_W-1:0] rx_word,
  output logic              word_done
);
  import sws_pkg::*;

  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int IDX_W = $clog2(DATA_W);

  logic [LEN_W-1:0] len_bits;
  logic [IDX_W-1:0] anchor;
  logic             first_bit, last_bit;

  always_comb begin
    case (wl_code_e'(wl_sel))
      WL_8:    len_bits = LEN_W'(8);
      WL_12:   len_bits = LEN_W'(12);
      WL_16:   len_bits = LEN_W'(16);
      WL_32:   len_bits = LEN_W'(MAX_LEN);
      default: len_bits = LEN_W'(24);
    endcase
  end

  assign anchor = align16 ? IDX_W'(NARROW_MSB) : IDX_W'(DATA_W - 1);

  sws_bit_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .bit_en(bit_en), .len_bits(len_bits),
    .first_bit(first_bit), .last_bit(last_bit)
  );

  sws_tx_shifter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .first_bit(first_bit),
    .anchor(anchor), .tx_word(tx_word), .tx_sdo(tx_sdo)
  );

  sws_rx_assembler #(
    .DATA_W(DATA_W), .NARROW_MSB(NARROW_MSB), .MAX_LEN(MAX_LEN),
    .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_rx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .last_bit(last_bit),
    .align16(align16), .anchor(anchor), .len_bits(len_bits),
    .rx_sdi(rx_sdi), .rx_word(rx_word), .word_done(word_done)
  );
endmodule

// File: tb/tb_serial_word_shifter.sv
`timescale 1ns/1ps
module tb_serial_word_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic [2:0]  wl_sel = 3'd3;
  logic        align16 = 1'b0;
  logic [23:0] tx_word = '0;
  logic        rx_sdi = 1'b0;
  logic        tx_sdo;
  logic [23:0] rx_word;
  logic        word_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_word_shifter dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .wl_sel(wl_sel), .align16(align16),
    .tx_word(tx_word), .rx_sdi(rx_sdi), .tx_sdo(tx_sdo), .rx_word(rx_word),
    .word_done(word_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic sdi);
    bit_en = en;
    rx_sdi = sdi;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int len_of(input logic [2:0] wl);
    case (wl)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd4: return 32;
      default: return 24;
    endcase
  endfunction

  function automatic logic exp_tx(input logic [23:0] w, input bit a16, input int i);
    int a = a16 ? 15 : 23;
    if (i <= a) return w[a - i];
    return 1'b0;
  endfunction

  function automatic logic [23:0] exp_rx(input logic [31:0] pat, input bit a16, input int len);
    logic [23:0] r = '0;
    int a = a16 ? 15 : 23;
    for (int i = 0; i < len; i++)
      if (a - i >= 0) r[a - i] = pat[31 - i];
    return r;
  endfunction

  // One word: drives len enabled bits, then gap idle cycles.
  task automatic run_word(input logic [2:0] wl, input bit a16, input logic [23:0] txw,
                          input logic [31:0] pat, input int gap, input bit chg,
                          input string req);
    int len = len_of(wl);
    bit illegal = a16 && (len > 16);
    logic [23:0] prev_rx = rx_word;
    logic last_sdo;
    wl_sel = wl;
    align16 = a16;
    tx_word = txw;
    if (illegal) $display("NOTE illegal configuration: %0d-bit length with bit-15 anchor, data not checked", len);
    for (int i = 0; i < len; i++) begin
      step(1'b1, pat[31 - i]);
      if (chg && i == 1) tx_word = ~txw;  // R9: later change must not matter
      if (!illegal)
        chk(tx_sdo == exp_tx(txw, a16, i), req, $sformatf("tx bit %0d", i),
            32'(tx_sdo), 32'(exp_tx(txw, a16, i)));
      chk(word_done == (i == len - 1), "R7", $sformatf("word_done at bit %0d", i),
          32'(word_done), 32'(i == len - 1));
      if (i < len - 1)
        chk(rx_word == prev_rx, "R7", "rx_word held mid-word", 32'(rx_word), 32'(prev_rx));
      else if (!illegal)
        chk(rx_word == exp_rx(pat, a16, len), req, "rx_word",
            32'(rx_word), 32'(exp_rx(pat, a16, len)));
    end
    last_sdo = tx_sdo;
    prev_rx = rx_word;
    for (int g = 0; g < gap; g++) begin
      step(1'b0, ~rx_sdi);
      chk(tx_sdo == last_sdo, "R8", "tx_sdo held while idle", 32'(tx_sdo), 32'(last_sdo));
      chk(rx_word == prev_rx, "R8", "rx_word held while idle", 32'(rx_word), 32'(prev_rx));
      chk(word_done == 1'b0, "R7", "word_done low while idle", 32'(word_done), 32'd0);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) step(1'b1, 1'b1);
    chk(tx_sdo == 1'b0 && rx_word == '0 && word_done == 1'b0, "R1", "outputs in reset",
        {7'd0, tx_sdo, rx_word}, 32'd0);
    rst = 1'b0;
    step(1'b0, 1'b0);
    chk(tx_sdo == 1'b0 && rx_word == '0 && word_done == 1'b0, "R1", "outputs after reset",
        {7'd0, tx_sdo, rx_word}, 32'd0);
  endtask

  task automatic t_wide_anchor;   // R3 R5 R2
    run_word(3'd3, 1'b0, 24'hA5C3F0, 32'h96E1_3C00, 2, 1'b0, "R3/R5 24b");
    run_word(3'd0, 1'b0, 24'hC35A5A, 32'hB7FF_FFFF, 3, 1'b0, "R3/R5 8b");
    run_word(3'd1, 1'b0, 24'h9F0123, 32'hD2B0_0000, 1, 1'b0, "R3/R5 12b");
    run_word(3'd2, 1'b0, 24'h8001FF, 32'hF00F_5555, 2, 1'b0, "R3/R5 16b");
    run_word(3'd4, 1'b0, 24'h5AA5C3, 32'h8123_45FF, 1, 1'b0, "R3/R5 32b");
    run_word(3'd6, 1'b0, 24'h123456, 32'h6543_2100, 1, 1'b0, "R2 code6 as 24b");
  endtask

  task automatic t_narrow_anchor; // R4 R6
    run_word(3'd2, 1'b1, 24'hFFA55A, 32'hC001_FFFF, 2, 1'b0, "R4/R6 16b");
    run_word(3'd0, 1'b1, 24'hEE81FF, 32'h81FF_FFFF, 1, 1'b0, "R4/R6 8b");
    run_word(3'd1, 1'b1, 24'h00F00F, 32'hA5F0_0000, 2, 1'b0, "R4/R6 12b");
  endtask

  task automatic t_capture;       // R9
    run_word(3'd3, 1'b0, 24'hF0F0F0, 32'h0F0F_0F00, 1, 1'b1, "R9 24b");
    run_word(3'd2, 1'b1, 24'h00C3A5, 32'h3C3C_0000, 1, 1'b1, "R9 16b");
  endtask

  task automatic t_continuous;    // R10
    run_word(3'd0, 1'b0, 24'h3C0000, 32'hE100_0000, 0, 1'b0, "R10 b2b first");
    run_word(3'd1, 1'b1, 24'h00ABC0, 32'h5A50_0000, 0, 1'b0, "R10 b2b second");
    run_word(3'd0, 1'b0, 24'hFF0000, 32'h0100_0000, 2, 1'b0, "R10 b2b third");
  endtask

  task automatic t_illegal;
    run_word(3'd3, 1'b1, 24'h123456, 32'hFFFF_FF00, 1, 1'b0, "R6 illegal");
    run_word(3'd0, 1'b0, 24'h990000, 32'h6600_0000, 1, 1'b0, "R2 after illegal");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_wide_anchor();
    t_narrow_anchor();
    t_capture();
    t_continuous();
    t_illegal();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule